// File: doc/BRIEF.md
# Four-Wide In-Order Issue Slotter

This block sits between a decoded-instruction buffer and the execution pipes of an in-order core. It receives a group of up to four decoded instructions, each carrying a class code and three register indices. On every cycle it scans the part of the group that has not yet issued, in program order. It issues the longest prefix that is free of hazards: the group's own unit limits, register dependences inside the group, and a load-use window on the load issued one cycle earlier.

Each issuing position gets a functional-unit code. The unit mix is two integer ALUs, one memory pipe and one floating-point pipe. Only ALU-A does shifts and multiplies, and only ALU-B does branches. The buffer accepts a new group only when the old one is fully drained. A flush input drops whatever remains.

Top module: `issue_slotter`

## Requirements
- R1: After reset the buffer is empty. `grp_ready` is 1, `iss_vld` is 0, `iss_cnt` is 0 and `stall` is 0.
- R2: Positions issue strictly in order. If one position is blocked, no later position issues in that cycle. `iss_cnt` equals the number of set bits in `iss_vld`, and this is never more than four.
- R3: A group is accepted on a clock edge where `grp_valid` and `grp_ready` are both 1. `grp_ready` is 1 only when no position will remain after this cycle's issue. Positions at or above `grp_len` are not loaded.
- R4: Class codes are NOP=0, ALU=1, SHIFT/MUL=2, BRANCH=3, LOAD=4, STORE=5 and FP=6; code 7 acts as NOP. Unit codes in `iss_fu` (two bits per position, position 0 in the low bits) are ALU-A=0, ALU-B=1, MEM=2 and FP=3. LOAD and STORE go to MEM, and FP goes to FP.
- R5: A plain ALU op takes ALU-A if it is still free in this cycle, and otherwise ALU-B. SHIFT/MUL may use only ALU-A, and BRANCH may use only ALU-B.
- R6: No unit is given to more than one position in the same cycle. A position whose unit is already taken blocks.
- R7: A non-NOP position blocks if either of its source registers equals the nonzero destination of an earlier, unissued position in the same group. Register 0 never creates a dependence.
- R8: A non-NOP position blocks if either of its sources equals the nonzero destination of a LOAD issued in the previous cycle.
- R9: A NOP takes an issue position and counts in `iss_cnt`, but it uses no unit, has no operands, and reports unit field 0.
- R10: `stall` is 1 exactly when the buffer holds instructions, no flush is active, and nothing issues.
- R11: While `flush` is 1, nothing issues and no group is accepted. On the next cycle the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop the remaining group |
| grp_valid | input | 1 | New group offered |
| grp_ready | output | 1 | Group can be accepted this edge |
| grp_len | input | 3 | Instructions in offered group (0..4) |
| grp_cls | input | 12 | 3-bit class per position |
| grp_dst | input | 4*RW | Destination register per position |
| grp_src1 | input | 4*RW | First source register per position |
| grp_src2 | input | 4*RW | Second source register per position |
| iss_vld | output | 4 | Position issues this cycle |
| iss_fu | output | 8 | 2-bit unit code per position |
| iss_cnt | output | 3 | Number of positions issued |
| stall | output | 1 | Buffer occupied but nothing issued |

## Verification
A wrong internal state shows at the ports within one cycle. If a stale valid bit is left in the buffer, `grp_ready` stays low. A lost valid bit makes the group end early. Both appear as a wrong `iss_vld` or `grp_ready` in the very next cycle. A corrupted load tracker shows in the cycle after a load: a wrong `stall` value, or an early issue of the consumer. A wrong unit preference shows at once as a swapped ALU code, or as a later SHIFT/MUL or BRANCH in the same group issuing a cycle late.

// File: rtl/issue_slotter.sv
module issue_slotter #(
  parameter int RW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              grp_valid,
  output logic              grp_ready,
  input  logic [2:0]        grp_len,
  input  logic [11:0]       grp_cls,
  input  logic [4*RW-1:0]   grp_dst,
  input  logic [4*RW-1:0]   grp_src1,
  input  logic [4*RW-1:0]   grp_src2,
  output logic [3:0]        iss_vld,
  output logic [7:0]        iss_fu,
  output logic [2:0]        iss_cnt,
  output logic              stall
);
  localparam int NP = 4;
  localparam logic [2:0] C_NOP = 3'd0, C_ALU = 3'd1, C_SHM = 3'd2, C_BR = 3'd3,
                         C_LD = 3'd4, C_ST = 3'd5, C_FP = 3'd6;
  localparam logic [1:0] U_A = 2'd0, U_B = 2'd1, U_M = 2'd2, U_F = 2'd3;

  logic [NP-1:0] ent_vld;
  logic [2:0]    ent_cls [NP];
  logic [RW-1:0] ent_d   [NP];
  logic [RW-1:0] ent_s1  [NP];
  logic [RW-1:0] ent_s2  [NP];
  logic          ld_v;
  logic [RW-1:0] ld_d;

  logic [NP-1:0] iss;
  logic [1:0]    fu [NP];
  logic [2:0]    cnt;

  always_comb begin
    logic ua, ub, um, uf, blk, dep, ok;
    logic [1:0] u;
    ua = 1'b0; ub = 1'b0; um = 1'b0; uf = 1'b0; blk = 1'b0;
    iss = '0; cnt = '0;
    for (int i = 0; i < NP; i++) fu[i] = U_A;
    for (int i = 0; i < NP; i++) begin
      if (ent_vld[i] && !blk && !flush) begin
        dep = 1'b0;
        ok  = 1'b0;
        u   = U_A;
        if (ent_cls[i] != C_NOP && ent_cls[i] != 3'd7) begin
          for (int j = 0; j < NP; j++)
            if (j < i && ent_vld[j] && ent_d[j] != '0 &&
                (ent_s1[i] == ent_d[j] || ent_s2[i] == ent_d[j]))
              dep = 1'b1;
          if (ld_v && (ent_s1[i] == ld_d || ent_s2[i] == ld_d))
            dep = 1'b1;
        end
        case (ent_cls[i])
          C_ALU: if (!ua) begin ok = 1'b1; u = U_A; end
                 else if (!ub) begin ok = 1'b1; u = U_B; end
          C_SHM: if (!ua) begin ok = 1'b1; u = U_A; end
          C_BR:  if (!ub) begin ok = 1'b1; u = U_B; end
          C_LD, C_ST: if (!um) begin ok = 1'b1; u = U_M; end
          C_FP:  if (!uf) begin ok = 1'b1; u = U_F; end
          default: ok = 1'b1;
        endcase
        if (ok && !dep) begin
          iss[i] = 1'b1;
          cnt    = cnt + 3'd1;
          if (ent_cls[i] != C_NOP && ent_cls[i] != 3'd7) begin
            fu[i] = u;
            case (u)
              U_A: ua = 1'b1;
              U_B: ub = 1'b1;
              U_M: um = 1'b1;
              default: uf = 1'b1;
            endcase
          end
        end else begin
          blk = 1'b1;
        end
      end
    end
  end

  assign iss_vld   = iss;
  assign iss_cnt   = cnt;
  assign iss_fu    = {fu[3], fu[2], fu[1], fu[0]};
  assign grp_ready = !flush && ((ent_vld & ~iss) == '0);
  assign stall     = !flush && (ent_vld != '0) && (iss == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld <= '0;
      ld_v    <= 1'b0;
      ld_d    <= '0;
      for (int i = 0; i < NP; i++) begin
        ent_cls[i] <= C_NOP;
        ent_d[i]   <= '0;
        ent_s1[i]  <= '0;
        ent_s2[i]  <= '0;
      end
    end else begin
      ld_v <= 1'b0;
      for (int i = 0; i < NP; i++)
        if (iss[i] && ent_cls[i] == C_LD && ent_d[i] != '0) begin
          ld_v <= 1'b1;
          ld_d <= ent_d[i];
        end
      if (flush) begin
        ent_vld <= '0;
      end else if (grp_valid && grp_ready) begin
        for (int i = 0; i < NP; i++) begin
          ent_vld[i] <= (3'(i) < grp_len);
          ent_cls[i] <= grp_cls[3*i +: 3];
          ent_d[i]   <= grp_dst[RW*i +: RW];
          ent_s1[i]  <= grp_src1[RW*i +: RW];
          ent_s2[i]  <= grp_src2[RW*i +: RW];
        end
      end else begin
        ent_vld <= ent_vld & ~iss;
      end
    end
  end

  logic [NP-1:0] on_a, on_b, on_m, on_f, rd_hit;
  logic          chk_v;
  logic [RW-1:0] chk_d;
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      logic real_op;
      real_op   = iss_vld[i] && ent_cls[i] != C_NOP && ent_cls[i] != 3'd7;
      on_a[i]   = real_op && iss_fu[2*i +: 2] == U_A;
      on_b[i]   = real_op && iss_fu[2*i +: 2] == U_B;
      on_m[i]   = real_op && iss_fu[2*i +: 2] == U_M;
      on_f[i]   = real_op && iss_fu[2*i +: 2] == U_F;
      rd_hit[i] = real_op && (ent_s1[i] == chk_d || ent_s2[i] == chk_d);
    end
  end
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_v <= 1'b0;
      chk_d <= '0;
    end else begin
      chk_v <= 1'b0;
      for (int i = 0; i < NP; i++)
        if (iss_vld[i] && ent_cls[i] == C_LD && ent_d[i] != '0) begin
          chk_v <= 1'b1;
          chk_d <= ent_d[i];
        end
    end
  end

  AST_ALU_A_ONCE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(on_a)); // R6
  AST_ALU_B_ONCE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(on_b)); // R6
  AST_MEM_ONCE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(on_m)); // R6
  AST_FP_ONCE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(on_f)); // R6
  AST_ISSUE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (iss_vld & ~ent_vld) == '0); // R2
  AST_CNT_BITS: assert property (@(posedge clk) disable iff (!rst_n) iss_cnt == 3'($countones(iss_vld))); // R2
  AST_NO_PARTIAL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_ready |=> (ent_vld & ~$past(ent_vld)) == '0); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush |=> ent_vld == '0); // R11
  AST_LOAD_USE: assert property (@(posedge clk) disable iff (!rst_n) chk_v |-> rd_hit == '0); // R8
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (iss_vld == '0 && ent_vld != '0)); // R10
endmodule

// File: tb/test_issue_slotter.sv
module test_issue_slotter;
  localparam int RW = 5;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, grp_valid = 1'b0;
  logic grp_ready, stall;
  logic [2:0] grp_len = '0, iss_cnt;
  logic [11:0] grp_cls = '0;
  logic [4*RW-1:0] grp_dst = '0, grp_src1 = '0, grp_src2 = '0;
  logic [3:0] iss_vld;
  logic [7:0] iss_fu;

  issue_slotter #(.RW(RW)) i_issue_slotter (
    .clk(clk), .rst_n(rst_n), .flush(flush), .grp_valid(grp_valid),
    .grp_ready(grp_ready), .grp_len(grp_len), .grp_cls(grp_cls),
    .grp_dst(grp_dst), .grp_src1(grp_src1), .grp_src2(grp_src2),
    .iss_vld(iss_vld), .iss_fu(iss_fu), .iss_cnt(iss_cnt), .stall(stall));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  logic [16:0] exp_q [$];
  string tag_q [$];

  task automatic ins(input int p, input logic [2:0] c, input int d, input int s1, input int s2);
    grp_cls[3*p +: 3]   = c;
    grp_dst[RW*p +: RW]  = RW'(d);
    grp_src1[RW*p +: RW] = RW'(s1);
    grp_src2[RW*p +: RW] = RW'(s2);
  endtask

  task automatic expect_c(input logic [3:0] v, input logic [7:0] f, input logic [2:0] c,
                          input logic s, input logic r, input string t);
    exp_q.push_back({v, f, c, s, r});
    tag_q.push_back(t);
  endtask

  task automatic check(input string t, input logic [16:0] act, input logic [16:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act vld=%b fu=%b cnt=%0d stall=%b rdy=%b exp vld=%b fu=%b cnt=%0d stall=%b rdy=%b",
               t, act[16:13], act[12:5], act[4:2], act[1], act[0],
               exp[16:13], exp[12:5], exp[4:2], exp[1], exp[0]);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [16:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {iss_vld, iss_fu, iss_cnt, stall, grp_ready}, e);
    end
  end

  task automatic load(input logic [2:0] len);
    grp_len = len;
    grp_valid = 1'b1;
    @(posedge clk); #1;
    grp_valid = 1'b0;
  endtask

  task automatic drain;
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", {iss_vld, iss_fu, iss_cnt, stall, grp_ready}, {4'b0, 8'b0, 3'd0, 1'b0, 1'b1});

    // R4 R5: four independent ops, one per unit
    ins(0, 3'd1, 1, 2, 3); ins(1, 3'd4, 4, 5, 0); ins(2, 3'd6, 6, 7, 0); ins(3, 3'd3, 0, 8, 0);
    load(3'd4);
    expect_c(4'b1111, 8'b01_11_10_00, 3'd4, 1'b0, 1'b1, "R4 full mix");
    drain();

    // R5 R6 R2: asymmetric ALUs
    ins(0, 3'd2, 1, 0, 0); ins(1, 3'd2, 2, 0, 0); ins(2, 3'd1, 3, 0, 0); ins(3, 3'd3, 0, 0, 0);
    load(3'd4);
    expect_c(4'b0001, 8'b00_00_00_00, 3'd1, 1'b0, 1'b0, "R6 second shift blocked");
    expect_c(4'b0110, 8'b00_01_00_00, 3'd2, 1'b0, 1'b0, "R5 alu falls to ALU-B");
    expect_c(4'b1000, 8'b01_00_00_00, 3'd1, 1'b0, 1'b1, "R5 branch on ALU-B");
    drain();

    // R7 R9: register 0 exempt, dependence blocks, NOP issues
    ins(0, 3'd1, 0, 1, 2); ins(1, 3'd1, 5, 0, 0); ins(2, 3'd4, 9, 5, 0); ins(3, 3'd0, 5, 9, 9);
    load(3'd4);
    expect_c(4'b0011, 8'b00_00_01_00, 3'd2, 1'b0, 1'b0, "R7 r0 no dep, r5 dep blocks");
    expect_c(4'b1100, 8'b00_10_00_00, 3'd2, 1'b0, 1'b1, "R9 NOP issues no unit");
    drain();

    // R8 R10: load-use stall
    ins(0, 3'd4, 3, 1, 0); ins(1, 3'd1, 5, 1, 2); ins(2, 3'd1, 6, 3, 2); ins(3, 3'd5, 0, 6, 1);
    load(3'd4);
    expect_c(4'b0011, 8'b00_00_00_10, 3'd2, 1'b0, 1'b0, "R7 intra load dep");
    expect_c(4'b0000, 8'b00_00_00_00, 3'd0, 1'b1, 1'b0, "R8 R10 load-use stall");
    expect_c(4'b0100, 8'b00_00_00_00, 3'd1, 1'b0, 1'b0, "R8 consumer issues after");
    expect_c(4'b1000, 8'b10_00_00_00, 3'd1, 1'b0, 1'b1, "R2 store last");
    drain();

    // R3: second group held out until the first drains
    ins(0, 3'd6, 10, 0, 0); ins(1, 3'd6, 11, 0, 0); ins(2, 3'd2, 12, 0, 0); ins(3, 3'd2, 13, 0, 0);
    load(3'd2);
    grp_valid = 1'b1;
    ins(0, 3'd1, 1, 0, 0); ins(1, 3'd1, 2, 0, 0); ins(2, 3'd1, 3, 0, 0); ins(3, 3'd3, 0, 0, 0);
    grp_len = 3'd3;
    expect_c(4'b0001, 8'b00_00_00_11, 3'd1, 1'b0, 1'b0, "R3 first FP, no refill");
    expect_c(4'b0010, 8'b00_00_11_00, 3'd1, 1'b0, 1'b1, "R3 last FP, ready");
    expect_c(4'b0011, 8'b00_00_01_00, 3'd2, 1'b0, 1'b0, "R3 new group at once");
    expect_c(4'b0100, 8'b00_00_00_00, 3'd1, 1'b0, 1'b1, "R3 len limits group");
    wait (exp_q.size() == 2);
    @(posedge clk); #1;
    grp_valid = 1'b0;
    drain();

    // R11: flush
    ins(0, 3'd5, 0, 1, 0); ins(1, 3'd5, 0, 2, 0); ins(2, 3'd5, 0, 3, 0); ins(3, 3'd5, 0, 4, 0);
    load(3'd4);
    expect_c(4'b0001, 8'b00_00_00_10, 3'd1, 1'b0, 1'b0, "R6 one store per cycle");
    drain();
    flush = 1'b1;
    grp_valid = 1'b1;
    #1;
    check("R11 flush blocks issue", {iss_vld, iss_fu, iss_cnt, stall, grp_ready}, {4'b0, 8'b0, 3'd0, 1'b0, 1'b0});
    @(posedge clk); #1;
    flush = 1'b0;
    grp_valid = 1'b0;
    expect_c(4'b0000, 8'b0, 3'd0, 1'b0, 1'b1, "R11 empty after flush");
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule